// File: doc/BRIEF.md
# Direct-Mapped Second-Level Cache Controller

This block sequences a direct-mapped, zero-wait-state second-level cache. The cache is indexed with virtual-address bits and tagged with physical-address bits. A requester presents a virtual address, the physical tag it got from address translation, a read or write flag, byte enables and a write-policy flag. In the same cycle the controller looks up its tag store and reports a hit or a miss. On a hit it strobes the external data arrays. On a miss it raises `busy_o` and works through a simple memory port. Each memory transaction is held until the memory acknowledges it.

The write policy is chosen for each access. Copy-back writes allocate the line on a miss and then mark it dirty without touching memory. Write-through writes go to memory and update the array only if the line is already present. They never allocate. The `LARGE` parameter picks the line organisation. In the large organisation each line has two 32-byte sub-blocks, and each sub-block has its own valid and dirty bit. In the small organisation each line has a single sub-block. `IDX_W` sets the number of lines: 14 gives the full 16384-line array, and the default is smaller so that default elaboration stays light. Reset and an invalidate-all command clear the tag store one index per cycle.

A requester that sees `busy_o` high keeps its request stable. The access completes in the first cycle in which `req_valid_i` is high and `busy_o` is low.

Top module: `cc_vipt_ctrl`

## Requirements
- R1: After reset is released, `busy_o` stays high for exactly 2^IDX_W cycles while every index is invalidated. During reset `busy_o` is high and `mem_req_o` is low. After the walk, every lookup misses.
- R2: `inv_all_i` high in an idle cycle refuses that cycle's request (`busy_o` high) and starts a walk in which `busy_o` stays high for 2^IDX_W further cycles. Lines that were present before the walk miss after it.
- R3: With `LARGE`=1 the line index is vaddr[IDX_W+5:6], the sub-block is vaddr[5] and the 64-bit word is vaddr[4:3]. These appear on `arr_idx_o`, `arr_sub_o` and `arr_word_o`.
- R4: With `LARGE`=0 the line index is vaddr[IDX_W+4:5], `arr_sub_o` is 0 and the word is vaddr[4:3].
- R5: A read hit completes in the lookup cycle. In that cycle `hit_o` and `arr_rd_o` are high, `busy_o` is low and no memory request is made.
- R6: A read miss holds `busy_o` high until a line fill is acknowledged. A fill is `mem_op_o`=0, carrying the physical tag, the index and the sub-block. The held request then completes as a hit.
- R7: A hit requires the stored tag to equal `req_ptag_i`. The same virtual index with another physical tag misses.
- R8: A copy-back write hit completes with no wait, with `arr_wr_o` high and no memory request, and it marks the sub-block dirty.
- R9: A copy-back write miss fills the line first, then completes as a write hit with `arr_wr_o` high.
- R10: Every write-through write issues one word write (`mem_op_o`=2) and then completes. `arr_wr_o` is high at completion only if the line was present. A write-through miss allocates nothing.
- R11: A miss that replaces a line with another tag issues writebacks (`mem_op_o`=1, old tag) for that line's valid dirty sub-blocks before the fill. A clean victim gets no writeback.
- R12: In the large organisation validity and dirtiness are kept per sub-block. Filling one sub-block leaves the other missing, replacement with a new tag drops the other sub-block, and writebacks go lowest sub-block first.
- R13: Once `mem_req_o` rises it stays high with stable op, tag, index and sub-block until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inv_all_i | input | 1 | Start an invalidate-all walk |
| req_valid_i | input | 1 | Request present |
| req_vaddr_i | input | 32 | Virtual address |
| req_ptag_i | input | TAG_W | Physical tag from translation |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 8 | Byte enables of the 64-bit word |
| req_copyback_i | input | 1 | 1 = copy-back with allocate, 0 = write-through without allocate |
| busy_o | output | 1 | Request stalled or refused |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup miss |
| arr_rd_o | output | 1 | Data array read strobe |
| arr_wr_o | output | 1 | Data array write strobe |
| arr_fill_o | output | 1 | Fill data from memory is being written into the array |
| arr_be_o | output | 8 | Byte enables to the array |
| arr_idx_o | output | IDX_W | Array line index |
| arr_sub_o | output | 1 | Array sub-block |
| arr_word_o | output | 2 | Array 64-bit word |
| mem_req_o | output | 1 | Memory transaction pending |
| mem_op_o | output | 2 | 0 fill, 1 writeback, 2 write-through word write |
| mem_tag_o | output | TAG_W | Physical tag of the transaction |
| mem_idx_o | output | IDX_W | Line index of the transaction |
| mem_sub_o | output | 1 | Sub-block of the transaction |
| mem_ack_i | input | 1 | Memory transaction complete |

## Verification
The assertions check some properties on every cycle. `busy_o` is high throughout a walk. Array strobes never coincide with a stall. A hit and a miss are never reported together. A fill is never requested while writebacks are still owed. A pending memory transaction holds its fields until it is acknowledged. Other behaviour can only be shown by the bench's access sequences: that a dirty victim is written back under its old tag, that write-through misses leave no line behind, that sub-blocks are tracked separately, that the walk lasts exactly one cycle per line, and that the two address slicings are correct. For these the bench predicts the exact stream of memory requests and the outcome of each access.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  typedef enum logic [1:0] {
    MEM_FILL = 2'd0,
    MEM_WB   = 2'd1,
    MEM_WT   = 2'd2
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_WALK,
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_WT
  } cc_state_e;
endpackage

// File: rtl/cc_addr_slice.sv
`timescale 1ns/1ps
module cc_addr_slice #(
  parameter int IDX_W = 8,
  parameter bit LARGE = 1'b1
) (
  input  logic [31:0]      vaddr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             sub_o,
  output logic [1:0]       word_o
);
  logic unused_va;
  assign unused_va = ^vaddr_i;
  assign word_o    = vaddr_i[4:3];

  generate
    if (LARGE) begin : g_two_sub
      assign idx_o = vaddr_i[6 +: IDX_W];
      assign sub_o = vaddr_i[5];
    end else begin : g_one_sub
      assign idx_o = vaddr_i[5 +: IDX_W];
      assign sub_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cc_tag_store.sv
`timescale 1ns/1ps
module cc_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 16,
  parameter int NSUB  = 2
) (
  input  logic             clk_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [NSUB-1:0]  rd_valid_o,
  output logic [NSUB-1:0]  rd_dirty_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [NSUB-1:0]  wr_valid_i,
  input  logic [NSUB-1:0]  wr_dirty_i
);
  localparam int LINES = 1 << IDX_W;
  localparam int ENT_W = TAG_W + 2 * NSUB;

  logic [ENT_W-1:0] mem_q [LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_idx_i] <= {wr_tag_i, wr_valid_i, wr_dirty_i};
  end

  assign {rd_tag_o, rd_valid_o, rd_dirty_o} = mem_q[rd_idx_i];
endmodule

// File: rtl/cc_ctrl.sv
`timescale 1ns/1ps
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int TAG_W = 16,
  parameter int NSUB  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inv_all_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             req_copyback_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic             req_sub_i,
  input  logic [TAG_W-1:0] req_ptag_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [NSUB-1:0]  valid_i,
  input  logic [NSUB-1:0]  dirty_i,
  output logic             busy_o,
  output logic             hit_o,
  output logic             miss_o,
  output logic             arr_rd_o,
  output logic             arr_wr_o,
  output logic             arr_fill_o,
  output logic             ts_we_o,
  output logic [IDX_W-1:0] ts_idx_o,
  output logic [TAG_W-1:0] ts_tag_o,
  output logic [NSUB-1:0]  ts_valid_o,
  output logic [NSUB-1:0]  ts_dirty_o,
  output logic             mem_req_o,
  output logic [1:0]       mem_op_o,
  output logic [TAG_W-1:0] mem_tag_o,
  output logic [IDX_W-1:0] mem_idx_o,
  output logic             mem_sub_o,
  input  logic             mem_ack_i
);
  localparam int LINES = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  cc_state_e        state_q;
  logic [IDX_W-1:0] cnt_q, idx_q;
  logic [TAG_W-1:0] ptag_q, vtag_q;
  logic             sub_q, keep_q, wt_done_q;
  logic [NSUB-1:0]  valid_q, dirty_q, wb_mask_q;

  logic [NSUB-1:0]  sub_mask, sub_mask_q, wb_mask_n, wb_bit;
  logic             lookup, tag_eq, hit, wt_write, need_mem, done, wb_sub;

  assign sub_mask   = NSUB'(1) << req_sub_i;
  assign sub_mask_q = NSUB'(1) << sub_q;
  assign lookup     = (state_q == ST_IDLE) && req_valid_i && !inv_all_i;
  assign tag_eq     = (tag_i == req_ptag_i);
  assign hit        = lookup && tag_eq && |(valid_i & sub_mask);
  assign wt_write   = req_write_i && !req_copyback_i;
  assign need_mem   = lookup && (wt_write ? !wt_done_q : !hit);
  assign done       = lookup && !need_mem;
  assign wb_mask_n  = tag_eq ? '0 : (valid_i & dirty_i);

  assign busy_o     = (state_q != ST_IDLE) || inv_all_i || need_mem;
  assign hit_o      = hit;
  assign miss_o     = lookup && !hit;
  assign arr_rd_o   = done && hit && !req_write_i;
  assign arr_wr_o   = done && hit && req_write_i;
  assign arr_fill_o = (state_q == ST_FILL) && mem_ack_i;

  // lowest pending dirty sub-block goes first
  always_comb begin
    wb_sub = 1'b0;
    for (int i = NSUB - 1; i >= 0; i--) begin
      if (wb_mask_q[i]) wb_sub = 1'(i);
    end
  end
  assign wb_bit = NSUB'(1) << wb_sub;

  assign mem_req_o = (state_q == ST_WB) || (state_q == ST_FILL) || (state_q == ST_WT);
  assign mem_op_o  = (state_q == ST_WB) ? MEM_WB : (state_q == ST_WT) ? MEM_WT : MEM_FILL;
  assign mem_tag_o = (state_q == ST_WB) ? vtag_q : ptag_q;
  assign mem_idx_o = idx_q;
  assign mem_sub_o = (state_q == ST_WB) ? wb_sub : sub_q;

  always_comb begin
    ts_we_o    = 1'b0;
    ts_idx_o   = req_idx_i;
    ts_tag_o   = tag_i;
    ts_valid_o = valid_i;
    ts_dirty_o = dirty_i;
    unique case (state_q)
      ST_WALK: begin
        ts_we_o    = 1'b1;
        ts_idx_o   = cnt_q;
        ts_tag_o   = '0;
        ts_valid_o = '0;
        ts_dirty_o = '0;
      end
      ST_IDLE: begin
        if (done && hit && req_write_i && req_copyback_i) begin
          ts_we_o    = 1'b1;
          ts_dirty_o = dirty_i | sub_mask;
        end
      end
      ST_FILL: begin
        if (mem_ack_i) begin
          ts_we_o    = 1'b1;
          ts_idx_o   = idx_q;
          ts_tag_o   = ptag_q;
          ts_valid_o = (keep_q ? valid_q : '0) | sub_mask_q;
          ts_dirty_o = keep_q ? (dirty_q & ~sub_mask_q) : '0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WALK;
      cnt_q     <= '0;
      idx_q     <= '0;
      sub_q     <= 1'b0;
      ptag_q    <= '0;
      vtag_q    <= '0;
      keep_q    <= 1'b0;
      valid_q   <= '0;
      dirty_q   <= '0;
      wb_mask_q <= '0;
      wt_done_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_WALK: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (inv_all_i) begin
            state_q   <= ST_WALK;
            cnt_q     <= '0;
            wt_done_q <= 1'b0;
          end else if (need_mem) begin
            idx_q   <= req_idx_i;
            sub_q   <= req_sub_i;
            ptag_q  <= req_ptag_i;
            vtag_q  <= tag_i;
            keep_q  <= tag_eq;
            valid_q <= valid_i;
            dirty_q <= dirty_i;
            if (wt_write) begin
              state_q <= ST_WT;
            end else begin
              wb_mask_q <= wb_mask_n;
              state_q   <= (|wb_mask_n) ? ST_WB : ST_FILL;
            end
          end else if (done) begin
            wt_done_q <= 1'b0;
          end
        end
        ST_WB: begin
          if (mem_ack_i) begin
            wb_mask_q <= wb_mask_q & ~wb_bit;
            if ((wb_mask_q & ~wb_bit) == '0) state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack_i) state_q <= ST_IDLE;
        end
        ST_WT: begin
          if (mem_ack_i) begin
            state_q   <= ST_IDLE;
            wt_done_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_walk_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WALK) |-> busy_o);

  assert_strobe_no_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_rd_o || arr_wr_o) |-> (!busy_o && !mem_req_o));

  assert_hit_miss_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  assert_wb_before_fill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_op_o == MEM_FILL) |-> (wb_mask_q == '0));

  assert_mem_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_op_o) && $stable(mem_tag_o)
                                   && $stable(mem_idx_o) && $stable(mem_sub_o)));
endmodule

// File: rtl/cc_vipt_ctrl.sv
`timescale 1ns/1ps
module cc_vipt_ctrl #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 16,
  parameter bit LARGE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inv_all_i,
  input  logic             req_valid_i,
  input  logic [31:0]      req_vaddr_i,
  input  logic [TAG_W-1:0] req_ptag_i,
  input  logic             req_write_i,
  input  logic [7:0]       req_be_i,
  input  logic             req_copyback_i,
  output logic             busy_o,
  output logic             hit_o,
  output logic             miss_o,
  output logic             arr_rd_o,
  output logic             arr_wr_o,
  output logic             arr_fill_o,
  output logic [7:0]       arr_be_o,
  output logic [IDX_W-1:0] arr_idx_o,
  output logic             arr_sub_o,
  output logic [1:0]       arr_word_o,
  output logic             mem_req_o,
  output logic [1:0]       mem_op_o,
  output logic [TAG_W-1:0] mem_tag_o,
  output logic [IDX_W-1:0] mem_idx_o,
  output logic             mem_sub_o,
  input  logic             mem_ack_i
);
  localparam int NSUB = LARGE ? 2 : 1;

  logic [IDX_W-1:0] idx, ts_idx;
  logic             sub, ts_we;
  logic [TAG_W-1:0] rd_tag, ts_tag;
  logic [NSUB-1:0]  rd_valid, rd_dirty, ts_valid, ts_dirty;

  cc_addr_slice #(.IDX_W(IDX_W), .LARGE(LARGE)) u_slice (
    .vaddr_i (req_vaddr_i),
    .idx_o   (idx),
    .sub_o   (sub),
    .word_o  (arr_word_o)
  );

  cc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .NSUB(NSUB)) u_tags (
    .clk_i      (clk_i),
    .rd_idx_i   (idx),
    .rd_tag_o   (rd_tag),
    .rd_valid_o (rd_valid),
    .rd_dirty_o (rd_dirty),
    .we_i       (ts_we),
    .wr_idx_i   (ts_idx),
    .wr_tag_i   (ts_tag),
    .wr_valid_i (ts_valid),
    .wr_dirty_i (ts_dirty)
  );

  cc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .NSUB(NSUB)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .inv_all_i      (inv_all_i),
    .req_valid_i    (req_valid_i),
    .req_write_i    (req_write_i),
    .req_copyback_i (req_copyback_i),
    .req_idx_i      (idx),
    .req_sub_i      (sub),
    .req_ptag_i     (req_ptag_i),
    .tag_i          (rd_tag),
    .valid_i        (rd_valid),
    .dirty_i        (rd_dirty),
    .busy_o         (busy_o),
    .hit_o          (hit_o),
    .miss_o         (miss_o),
    .arr_rd_o       (arr_rd_o),
    .arr_wr_o       (arr_wr_o),
    .arr_fill_o     (arr_fill_o),
    .ts_we_o        (ts_we),
    .ts_idx_o       (ts_idx),
    .ts_tag_o       (ts_tag),
    .ts_valid_o     (ts_valid),
    .ts_dirty_o     (ts_dirty),
    .mem_req_o      (mem_req_o),
    .mem_op_o       (mem_op_o),
    .mem_tag_o      (mem_tag_o),
    .mem_idx_o      (mem_idx_o),
    .mem_sub_o      (mem_sub_o),
    .mem_ack_i      (mem_ack_i)
  );

  assign arr_idx_o = idx;
  assign arr_sub_o = sub;
  assign arr_be_o  = req_be_i;
endmodule

// File: tb/sim_cc_vipt_ctrl.sv
`timescale 1ns/1ps
module sim_cc_vipt_ctrl;
  localparam int IDX_W = 4;
  localparam int TAG_W = 16;
  localparam int LINES = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             inv_all = 0, req_valid = 0, wr = 0, cb = 0;
  logic [31:0]      vaddr = '0;
  logic [TAG_W-1:0] ptag = '0;
  logic [7:0]       be = 8'hFF;

  logic             busy, hit, miss, arr_rd, arr_wr, arr_fill, arr_sub, mem_req, mem_sub;
  logic [7:0]       arr_be;
  logic [IDX_W-1:0] arr_idx, mem_idx;
  logic [1:0]       arr_word, mem_op;
  logic [TAG_W-1:0] mem_tag;
  logic             mem_ack = 1'b0;

  logic             s_busy, s_hit, s_miss, s_rd, s_wr, s_fill, s_sub, s_mreq, s_msub;
  logic [7:0]       s_be;
  logic [IDX_W-1:0] s_idx, s_midx;
  logic [1:0]       s_word, s_mop;
  logic [TAG_W-1:0] s_mtag;
  logic             s_ack = 1'b0;

  cc_vipt_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LARGE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .inv_all_i(inv_all), .req_valid_i(req_valid),
    .req_vaddr_i(vaddr), .req_ptag_i(ptag), .req_write_i(wr), .req_be_i(be),
    .req_copyback_i(cb), .busy_o(busy), .hit_o(hit), .miss_o(miss),
    .arr_rd_o(arr_rd), .arr_wr_o(arr_wr), .arr_fill_o(arr_fill), .arr_be_o(arr_be),
    .arr_idx_o(arr_idx), .arr_sub_o(arr_sub), .arr_word_o(arr_word),
    .mem_req_o(mem_req), .mem_op_o(mem_op), .mem_tag_o(mem_tag), .mem_idx_o(mem_idx),
    .mem_sub_o(mem_sub), .mem_ack_i(mem_ack)
  );

  cc_vipt_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LARGE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .inv_all_i(inv_all), .req_valid_i(req_valid),
    .req_vaddr_i(vaddr), .req_ptag_i(ptag), .req_write_i(wr), .req_be_i(be),
    .req_copyback_i(cb), .busy_o(s_busy), .hit_o(s_hit), .miss_o(s_miss),
    .arr_rd_o(s_rd), .arr_wr_o(s_wr), .arr_fill_o(s_fill), .arr_be_o(s_be),
    .arr_idx_o(s_idx), .arr_sub_o(s_sub), .arr_word_o(s_word),
    .mem_req_o(s_mreq), .mem_op_o(s_mop), .mem_tag_o(s_mtag), .mem_idx_o(s_midx),
    .mem_sub_o(s_msub), .mem_ack_i(s_ack)
  );

  int vectors = 0, miscompares = 0;

  typedef struct packed {
    logic [1:0]       op;
    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] idx;
    logic             sub;
  } mexp_t;
  mexp_t exp_q[$];

  localparam logic [1:0] OP_FILL = 2'd0, OP_WB = 2'd1, OP_WT = 2'd2;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic exp_mem(input logic [1:0] op, input int tag, input int idx, input int sub);
    mexp_t e;
    e.op  = op;
    e.tag = TAG_W'(tag);
    e.idx = IDX_W'(idx);
    e.sub = 1'(sub);
    exp_q.push_back(e);
  endtask

  function automatic logic [31:0] va(input int idx, input int sub);
    return 32'((idx << 6) | (sub << 5));
  endfunction

  // monitor: memory responder that pops and compares expected requests
  initial begin
    int dly;
    logic [1:0] first_op;
    mexp_t e, got;
    dly = 0;
    first_op = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (dly == 0) first_op = mem_op;
        if (dly == 2) begin
          got = '{mem_op, mem_tag, mem_idx, mem_sub};
          if (exp_q.size() == 0) begin
            chk(1'b0, "R11", "unexpected memory request", longint'(got), 0);
          end else begin
            e = exp_q.pop_front();
            chk(got == e, "R11", "memory request op/tag/idx/sub", longint'(got), longint'(e));
          end
          chk(mem_op == first_op, "R13", "op held until ack", mem_op, first_op);
          mem_ack = 1'b1;
          dly = 0;
        end else dly++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      s_ack = s_mreq && !s_ack;
    end
  end

  // driver: hold request until busy drops, report completion-cycle outputs
  task automatic access(input logic [31:0] a, input int t, input bit w, input bit c,
                        output bit h, output bit rd, output bit wrs, output int stall);
    @(negedge clk);
    vaddr = a; ptag = TAG_W'(t); wr = w; cb = c; be = 8'hFF; req_valid = 1'b1;
    #1;
    stall = 0;
    while (busy && stall < 500) begin
      @(negedge clk);
      #1;
      stall++;
    end
    h = hit; rd = arr_rd; wrs = arr_wr;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic done_q(input string req);
    chk(exp_q.size() == 0, req, "memory requests still expected", exp_q.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL R6 watchdog: actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit h, rd, w;
    int st, n;

    // R1: reset state and walk length
    repeat (2) @(negedge clk);
    #1;
    chk(busy == 1'b1 && mem_req == 1'b0, "R1", "busy/mem_req in reset", {busy, mem_req}, 2'b10);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk(n == LINES, "R1", "busy cycles after reset", n, LINES);

    // R6 / R1: read miss after walk, fill, then completes as hit
    exp_mem(OP_FILL, 'h11, 1, 0);
    access(va(1, 0), 'h11, 0, 1, h, rd, w, st);
    chk(st > 0, "R6", "read miss stalls", st, 1);
    chk(h && rd && !w, "R6", "replay hit+rd", {h, rd, w}, 3'b110);
    done_q("R6");

    // R5: zero-wait read hit
    access(va(1, 0), 'h11, 0, 1, h, rd, w, st);
    chk(st == 0, "R5", "read hit stall cycles", st, 0);
    chk(h && rd, "R5", "read hit strobes", {h, rd}, 2'b11);
    done_q("R5");

    // R12: other sub-block still missing
    exp_mem(OP_FILL, 'h11, 1, 1);
    access(va(1, 1), 'h11, 0, 1, h, rd, w, st);
    chk(st > 0 && h, "R12", "sub-block 1 filled separately", st, 1);
    done_q("R12");

    // R7 / R11: different physical tag misses, clean victim: no writeback
    exp_mem(OP_FILL, 'h22, 1, 0);
    access(va(1, 0), 'h22, 0, 1, h, rd, w, st);
    chk(st > 0 && h && rd, "R7", "tag mismatch refill", st, 1);
    done_q("R7");

    // R12: replacement dropped sub-block 1
    exp_mem(OP_FILL, 'h22, 1, 1);
    access(va(1, 1), 'h22, 0, 1, h, rd, w, st);
    chk(st > 0, "R12", "other sub-block dropped on replace", st, 1);
    done_q("R12");

    // R8: copy-back write hit
    access(va(1, 0), 'h22, 1, 1, h, rd, w, st);
    chk(st == 0, "R8", "cb write hit stall", st, 0);
    chk(h && w && !rd, "R8", "cb write hit strobes", {h, rd, w}, 3'b101);
    done_q("R8");

    // R9: copy-back write miss allocates
    exp_mem(OP_FILL, 'h33, 2, 0);
    access(va(2, 0), 'h33, 1, 1, h, rd, w, st);
    chk(st > 0, "R9", "cb write miss stalls", st, 1);
    chk(h && w, "R9", "allocate then write", {h, w}, 2'b11);
    done_q("R9");

    // R11: dirty victim written back (old tag) before fill; clean sub-block skipped
    exp_mem(OP_WB, 'h22, 1, 0);
    exp_mem(OP_FILL, 'h44, 1, 0);
    access(va(1, 0), 'h44, 0, 1, h, rd, w, st);
    chk(h && rd, "R11", "read after dirty eviction", {h, rd}, 2'b11);
    done_q("R11");

    // R10: write-through hit writes memory and array
    exp_mem(OP_WT, 'h44, 1, 0);
    access(va(1, 0), 'h44, 1, 0, h, rd, w, st);
    chk(st > 0 && h && w, "R10", "wt hit: memory then array", {h, w}, 2'b11);
    done_q("R10");

    // R10: write-through miss: memory only, no allocation
    exp_mem(OP_WT, 'h55, 3, 0);
    access(va(3, 0), 'h55, 1, 0, h, rd, w, st);
    chk(!w && !h, "R10", "wt miss no array write", {h, w}, 2'b00);
    done_q("R10");
    exp_mem(OP_FILL, 'h55, 3, 0);
    access(va(3, 0), 'h55, 0, 1, h, rd, w, st);
    chk(st > 0, "R10", "wt miss left no line", st, 1);
    done_q("R10");

    // R12: both dirty sub-blocks written back, lowest first
    exp_mem(OP_FILL, 'h33, 2, 1);
    access(va(2, 1), 'h33, 0, 1, h, rd, w, st);
    done_q("R12");
    access(va(2, 1), 'h33, 1, 1, h, rd, w, st);
    chk(st == 0 && w, "R8", "cb write hit sub-block 1", st, 0);
    exp_mem(OP_WB, 'h33, 2, 0);
    exp_mem(OP_WB, 'h33, 2, 1);
    exp_mem(OP_FILL, 'h66, 2, 0);
    access(va(2, 0), 'h66, 0, 1, h, rd, w, st);
    chk(h && rd, "R12", "read after two writebacks", {h, rd}, 2'b11);
    done_q("R12");

    // R3 / R4: address slicing in both organisations
    @(negedge clk);
    vaddr = 32'h0000_02F8;
    #1;
    chk(arr_idx == 4'hB && arr_sub == 1'b1 && arr_word == 2'd3, "R3", "large slice",
        {arr_idx, arr_sub, arr_word}, {4'hB, 1'b1, 2'd3});
    chk(s_idx == 4'h7 && s_sub == 1'b0 && s_word == 2'd3, "R4", "small slice",
        {s_idx, s_sub, s_word}, {4'h7, 1'b0, 2'd3});

    // R2: invalidate-all refuses the request and walks every line
    @(negedge clk);
    vaddr = va(1, 0); ptag = TAG_W'('h44); wr = 1'b0; cb = 1'b1;
    req_valid = 1'b1; inv_all = 1'b1;
    #1;
    chk(busy == 1'b1 && arr_rd == 1'b0, "R2", "request refused during inv_all",
        {busy, arr_rd}, 2'b10);
    n = 1;
    @(negedge clk);
    inv_all = 1'b0; req_valid = 1'b0;
    #1;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk(n == LINES + 1, "R2", "busy cycles for inv_all", n, LINES + 1);
    exp_mem(OP_FILL, 'h44, 1, 0);
    access(va(1, 0), 'h44, 0, 1, h, rd, w, st);
    chk(st > 0, "R2", "line gone after invalidate", st, 1);
    done_q("R2");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule